// File: doc/BRIEF.md
# Endpoint Buffer Parallel Access Port

This block sits between a microcontroller's parallel bus and the packet buffers of a USB device's endpoints. The host processor first writes a command byte with the select line `a0` high. That byte names an operation and an endpoint. Data phases follow with `a0` low. In these phases a packet, prefixed by its length, streams into or out of that endpoint's buffer. The bus runs in byte mode or word mode. Both modes share one byte layout in the buffer, so a packet written in one mode reads back correctly in the other.

Each endpoint has a stall bit, an interrupt flag, a buffer-full flag and a bank bit. The USB serial engine is not part of the block. It is reduced to two strobes: `usb_done` marks a finished packet on the endpoint given by `usb_ep`, and `usb_setup` marks a received SETUP token. Endpoints chosen by a parameter mask own two buffer banks. During a DMA transfer (`dma_act` high), a data phase that reaches the end of the active bank makes such an endpoint switch to the other bank and continue from offset zero.

Top module: `ebp_port`

## Requirements
- R1: After reset, `dout` and `int_flags` are zero, and every endpoint's status byte reads 00h.
- R2: The command decode keeps the low nibble of the command byte as the endpoint number (0 = control OUT, 1 = control IN, 2 to 15 = endpoints 1 to 14). Codes 0nh select a buffer write and 1nh a buffer read. In byte mode (`wide_bus`=0), the first two data phases carry the length, low byte then high byte. Packet bytes follow in order, and a read returns the same sequence.
- R3: In word mode (`wide_bus`=1), the first data phase after a command is ignored on writes and reads as 0000h. The second phase carries the full 16-bit length. Each later word holds the lower-numbered byte on bits 7:0 and the next byte on bits 15:8.
- R4: In word mode, for an odd length, the upper byte of the last data word is not written, and it reads back as zero.
- R5: A packet written in word mode reads back in byte mode as its length bytes followed by its data bytes in order.
- R6: Every command phase restarts the data sequence at the length prefix and buffer offset zero.
- R7: Code 5nh selects status for endpoint n. Each data read returns {4'b0, int, bank, stall, full} in bits 7:0 and zeros above, then clears that endpoint's interrupt flag. The other status bits are left unchanged.
- R8: `usb_done` sets `int_flags[usb_ep]` and the full bit of that endpoint's active bank. A buffer-read command (1nh) clears the full bit of endpoint n.
- R9: Code 4nh sets the stall bit of endpoint n, and 6nh clears it. `usb_setup` clears the stall bits of endpoints 0 and 1 and sets `int_flags[0]`. When a stall command and `usb_setup` arrive in the same cycle, `usb_setup` wins.
- R10: With `dma_act` high, a data phase that brings the offset to the buffer end toggles the bank of a double-buffered endpoint (mask bit set; endpoint 2 by default) and restarts at offset zero. The length prefix then read is the other bank's length. An endpoint without a second bank wraps to offset zero of the same bank.
- R11: Read data appears on `dout` in the cycle after the read strobe and holds until the next data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_bus | input | 1 | 1 = 16-bit data phases, 0 = 8-bit |
| dma_act | input | 1 | Data phases come from a DMA transfer |
| bus_wr | input | 1 | Write strobe, one cycle per bus access |
| bus_rd | input | 1 | Read strobe, one cycle per bus access |
| a0 | input | 1 | 1 = command phase, 0 = data phase |
| din | input | 16 | Write data; command byte on bits 7:0 |
| dout | output | 16 | Read data |
| usb_done | input | 1 | Packet finished on endpoint `usb_ep` |
| usb_setup | input | 1 | SETUP token received |
| usb_ep | input | EP_W | Endpoint of `usb_done` |
| int_flags | output | NUM_EP | Per-endpoint interrupt flags |

## Verification
A read strobe seen at one rising edge puts its value on `dout` after that same edge. The scoreboard therefore pops its expected value at that edge and compares it one nanosecond later, before the driver moves any input at the falling edge. Strobes from the USB engine, command phases and status reads change `int_flags` and the status byte at the next rising edge. Those outputs are sampled at the following falling edge. A hold check on `dout`, several idle cycles after the last read, covers the output register.

// File: rtl/ebp_pkg.sv
package ebp_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_WR, K_RD, K_STAT, K_STALL, K_UNSTALL
  } cmd_kind_e;
endpackage

// File: rtl/ebp_cmd_decode.sv
module ebp_cmd_decode
  import ebp_pkg::*;
#(
  parameter int unsigned EP_W = 4
) (
  input  logic [7:0]      code,
  output cmd_kind_e       kind,
  output logic [EP_W-1:0] ep
);
  always_comb begin
    unique case (code[7:4])
      4'h0:    kind = K_WR;
      4'h1:    kind = K_RD;
      4'h4:    kind = K_STALL;
      4'h5:    kind = K_STAT;
      4'h6:    kind = K_UNSTALL;
      default: kind = K_NONE;
    endcase
    ep = code[EP_W-1:0];
  end
endmodule

// File: rtl/ebp_buf_mem.sv
module ebp_buf_mem #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/ebp_ep_state.sv
module ebp_ep_state #(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned EP_W = 4,
  parameter logic [NUM_EP-1:0] DBL_MASK = NUM_EP'(4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_stb,
  input  logic              setup_stb,
  input  logic [EP_W-1:0]   usb_ep,
  input  logic [EP_W-1:0]   cmd_ep,
  input  logic              stall_set,
  input  logic              stall_clr,
  input  logic              consume,
  input  logic [EP_W-1:0]   act_ep,
  input  logic              int_clr,
  input  logic              flip,
  output logic [NUM_EP-1:0] int_q,
  output logic [NUM_EP-1:0] stall_q,
  output logic [NUM_EP-1:0] bank_q,
  output logic [NUM_EP-1:0] full_q
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic [1:0] full_r;
    logic       hit_done, hit_cmd, hit_act;
    assign hit_done  = done_stb && (usb_ep == EP_W'(i));
    assign hit_cmd   = cmd_ep == EP_W'(i);
    assign hit_act   = act_ep == EP_W'(i);
    assign full_q[i] = full_r[bank_q[i]];

    always_ff @(posedge clk) begin
      if (rst) begin
        full_r     <= '0;
        int_q[i]   <= 1'b0;
        stall_q[i] <= 1'b0;
        bank_q[i]  <= 1'b0;
      end else begin
        if (setup_stb && i < 2)            stall_q[i] <= 1'b0;
        else if (stall_set && hit_cmd)     stall_q[i] <= 1'b1;
        else if (stall_clr && hit_cmd)     stall_q[i] <= 1'b0;

        if (hit_done || (setup_stb && i == 0)) int_q[i] <= 1'b1;
        else if (int_clr && hit_act)          int_q[i] <= 1'b0;

        if (hit_done)                 full_r[bank_q[i]] <= 1'b1;
        else if (consume && hit_cmd)  full_r[bank_q[i]] <= 1'b0;

        if (DBL_MASK[i] && flip && hit_act) bank_q[i] <= ~bank_q[i];
      end
    end
  end
endmodule

// File: rtl/ebp_port.sv
module ebp_port
  import ebp_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned BUF_BYTES = 64,
  parameter logic [NUM_EP-1:0] DBL_MASK = NUM_EP'(4),
  parameter int unsigned EP_W = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_bus,
  input  logic              dma_act,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              a0,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  input  logic              usb_done,
  input  logic              usb_setup,
  input  logic [EP_W-1:0]   usb_ep,
  output logic [NUM_EP-1:0] int_flags
);
  localparam int unsigned PTR_W = $clog2(BUF_BYTES);
  localparam int unsigned ROW_W = PTR_W - 1;
  localparam int unsigned AW    = EP_W + 1 + ROW_W;
  localparam int unsigned LI_W  = EP_W + 1;

  cmd_kind_e       dec_kind, kind_q;
  logic [EP_W-1:0] dec_ep, cur_ep_q;
  logic [1:0]      ph_q;
  logic [PTR_W-1:0] ptr_q;
  logic [15:0]     len_q [2*NUM_EP];

  logic            cmd_wr, data_wr, data_rd, data_any, in_data, buf_kind, stat_mode;
  logic [PTR_W:0]  ptr_nx;
  logic            at_end, roll;
  logic [NUM_EP-1:0] stall_vec, bank_vec, full_vec;
  logic            cur_bank;
  logic [LI_W-1:0] len_idx;
  logic [15:0]     len_cur;
  logic [16:0]     hi_idx;
  logic            hi_live;
  logic [AW-1:0]   addr;
  logic            we_lo, we_hi, re_mem;
  logic [7:0]      wd_hi, rd_lo, rd_hi;
  logic [7:0]      stat_byte;

  logic            data_sel_q, wide_q, lane_q, mask_hi_q;
  logic [15:0]     out_val_q;

  ebp_cmd_decode #(.EP_W(EP_W)) u_dec (
    .code (din[7:0]),
    .kind (dec_kind),
    .ep   (dec_ep)
  );

  assign cmd_wr    = bus_wr && a0;
  assign data_wr   = bus_wr && !a0;
  assign data_rd   = bus_rd && !a0;
  assign data_any  = data_wr || data_rd;
  assign in_data   = ph_q == 2'd2;
  assign buf_kind  = (kind_q == K_WR) || (kind_q == K_RD);
  assign stat_mode = kind_q == K_STAT;

  assign ptr_nx  = {1'b0, ptr_q} + (wide_bus ? (PTR_W+1)'(2) : (PTR_W+1)'(1));
  assign at_end  = ptr_nx == (PTR_W+1)'(BUF_BYTES);
  assign roll    = data_any && buf_kind && in_data && dma_act && at_end
                   && DBL_MASK[cur_ep_q];

  assign cur_bank = bank_vec[cur_ep_q];
  assign len_idx  = {cur_ep_q, cur_bank};
  assign len_cur  = len_q[len_idx];
  assign hi_idx   = 17'(ptr_q) + 17'd1;
  assign hi_live  = hi_idx < {1'b0, len_cur};
  assign addr     = {cur_ep_q, cur_bank, ptr_q[PTR_W-1:1]};

  assign we_lo  = data_wr && buf_kind && in_data && (wide_bus || !ptr_q[0]);
  assign we_hi  = data_wr && buf_kind && in_data && (wide_bus ? hi_live : ptr_q[0]);
  assign re_mem = data_rd && buf_kind && in_data;
  assign wd_hi  = wide_bus ? din[15:8] : din[7:0];

  ebp_buf_mem #(.AW(AW)) u_mem_lo (
    .clk(clk), .we(we_lo), .re(re_mem), .addr(addr), .wdata(din[7:0]), .rdata(rd_lo)
  );
  ebp_buf_mem #(.AW(AW)) u_mem_hi (
    .clk(clk), .we(we_hi), .re(re_mem), .addr(addr), .wdata(wd_hi), .rdata(rd_hi)
  );

  ebp_ep_state #(.NUM_EP(NUM_EP), .EP_W(EP_W), .DBL_MASK(DBL_MASK)) u_state (
    .clk       (clk),
    .rst       (rst),
    .done_stb  (usb_done),
    .setup_stb (usb_setup),
    .usb_ep    (usb_ep),
    .cmd_ep    (dec_ep),
    .stall_set (cmd_wr && dec_kind == K_STALL),
    .stall_clr (cmd_wr && dec_kind == K_UNSTALL),
    .consume   (cmd_wr && dec_kind == K_RD),
    .act_ep    (cur_ep_q),
    .int_clr   (data_rd && stat_mode),
    .flip      (roll),
    .int_q     (int_flags),
    .stall_q   (stall_vec),
    .bank_q    (bank_vec),
    .full_q    (full_vec)
  );

  assign stat_byte = {4'b0, int_flags[cur_ep_q], bank_vec[cur_ep_q],
                      stall_vec[cur_ep_q], full_vec[cur_ep_q]};

  // command and sequencing state
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= K_NONE;
      cur_ep_q <= '0;
      ph_q     <= '0;
      ptr_q    <= '0;
    end else if (cmd_wr) begin
      kind_q   <= dec_kind;
      cur_ep_q <= dec_ep;
      ph_q     <= '0;
      ptr_q    <= '0;
    end else if (data_any && buf_kind) begin
      if (!in_data)  ph_q  <= ph_q + 2'd1;
      else if (roll) ptr_q <= '0;
      else           ptr_q <= ptr_nx[PTR_W-1:0];
    end
  end

  // length prefix store, one entry per endpoint bank
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 2*NUM_EP; k++) len_q[k] <= '0;
    end else if (data_wr && buf_kind && !in_data) begin
      if (wide_bus) begin
        if (ph_q == 2'd1) len_q[len_idx] <= din;
      end else if (ph_q == 2'd0) begin
        len_q[len_idx][7:0] <= din[7:0];
      end else begin
        len_q[len_idx][15:8] <= din[7:0];
      end
    end
  end

  // read output registers
  always_ff @(posedge clk) begin
    if (rst) begin
      data_sel_q <= 1'b0;
      wide_q     <= 1'b0;
      lane_q     <= 1'b0;
      mask_hi_q  <= 1'b0;
      out_val_q  <= '0;
    end else if (data_rd) begin
      data_sel_q <= buf_kind && in_data;
      wide_q     <= wide_bus;
      lane_q     <= !wide_bus && ptr_q[0];
      mask_hi_q  <= wide_bus && !hi_live;
      if (stat_mode)                  out_val_q <= {8'h0, stat_byte};
      else if (!buf_kind)             out_val_q <= '0;
      else if (ph_q == 2'd0)          out_val_q <= wide_bus ? 16'h0 : {8'h0, len_cur[7:0]};
      else if (ph_q == 2'd1)          out_val_q <= wide_bus ? len_cur : {8'h0, len_cur[15:8]};
      else                            out_val_q <= '0;
    end
  end

  always_comb begin
    if (!data_sel_q)  dout = out_val_q;
    else if (wide_q)  dout = {mask_hi_q ? 8'h0 : rd_hi, rd_lo};
    else              dout = {8'h0, lane_q ? rd_hi : rd_lo};
  end
endmodule

// File: rtl/ebp_port_chk.sv
module ebp_port_chk #(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned EP_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              a0,
  input logic [15:0]       din,
  input logic [15:0]       dout,
  input logic              usb_done,
  input logic              usb_setup,
  input logic [EP_W-1:0]   usb_ep,
  input logic [NUM_EP-1:0] int_flags,
  input logic              stat_mode,
  input logic [EP_W-1:0]   cur_ep,
  input logic [NUM_EP-1:0] stall_vec
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (dout == 16'h0 && int_flags == '0)); // R1

  AST_STAT_CLEARS_INT: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !a0 && stat_mode && !usb_done && !usb_setup)
    |=> !int_flags[$past(cur_ep)]); // R7

  AST_DONE_RAISES_INT: assert property (@(posedge clk) disable iff (rst)
    usb_done |=> int_flags[$past(usb_ep)]); // R8

  AST_SETUP_EFFECT: assert property (@(posedge clk) disable iff (rst)
    usb_setup |=> (int_flags[0] && !stall_vec[0] && !stall_vec[1])); // R9

  AST_STALL_CMD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && a0 && din[7:4] == 4'h4 && !usb_setup)
    |=> stall_vec[$past(din[EP_W-1:0])]); // R9

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !a0) |=> $stable(dout)); // R11
endmodule

bind ebp_port ebp_port_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .a0        (a0),
  .din       (din),
  .dout      (dout),
  .usb_done  (usb_done),
  .usb_setup (usb_setup),
  .usb_ep    (usb_ep),
  .int_flags (int_flags),
  .stat_mode (stat_mode),
  .cur_ep    (cur_ep_q),
  .stall_vec (stall_vec)
);

// File: tb/ebp_port_tb.sv
`timescale 1ns/1ps
module ebp_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_bus = 1'b0, dma_act = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, a0 = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        usb_done = 1'b0, usb_setup = 1'b0;
  logic [3:0]  usb_ep = '0;
  logic [15:0] int_flags;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_exp = '0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  ebp_port u_dut (
    .clk(clk), .rst(rst), .wide_bus(wide_bus), .dma_act(dma_act),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .a0(a0), .din(din), .dout(dout),
    .usb_done(usb_done), .usb_setup(usb_setup), .usb_ep(usb_ep),
    .int_flags(int_flags)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: each data read is due one edge after its strobe
  initial forever begin
    @(posedge clk);
    if (bus_rd && !a0 && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      #1 chk(t, dout, e);
    end
  end

  task automatic cmd(input logic [7:0] c);
    @(negedge clk); a0 = 1'b1; bus_wr = 1'b1; din = {8'h0, c};
    @(negedge clk); a0 = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; din = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag); last_exp = e;
    @(negedge clk); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic done_pulse(input logic [3:0] ep);
    @(negedge clk); usb_done = 1'b1; usb_ep = ep;
    @(negedge clk); usb_done = 1'b0;
  endtask

  task automatic setup_pulse();
    @(negedge clk); usb_setup = 1'b1;
    @(negedge clk); usb_setup = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 dout", dout, 16'h0);
    chk("R1 int_flags", int_flags, 16'h0);
    cmd(8'h53); rd(16'h0000, "R1 status");

    // R2 byte mode round trip on endpoint 4
    cmd(8'h04); wr(16'h0003); wr(16'h0000); wr(16'h00A1); wr(16'h00B2); wr(16'h00C3);
    cmd(8'h14);
    rd(16'h0003, "R2"); rd(16'h0000, "R2"); rd(16'h00A1, "R2"); rd(16'h00B2, "R2");
    rd(16'h00C3, "R2");
    // R6 new command restarts at prefix
    cmd(8'h14); rd(16'h0003, "R6"); rd(16'h0000, "R6"); rd(16'h00A1, "R6");

    // R3/R4 word mode, odd length on endpoint 5
    wide_bus = 1'b1;
    cmd(8'h05); wr(16'hFFFF); wr(16'h0003); wr(16'h2211); wr(16'h9933);
    cmd(8'h15);
    rd(16'h0000, "R3"); rd(16'h0003, "R3"); rd(16'h2211, "R3"); rd(16'h0033, "R4");
    // R5 same packet in byte mode
    wide_bus = 1'b0;
    cmd(8'h15);
    rd(16'h0003, "R5"); rd(16'h0000, "R5"); rd(16'h0011, "R5"); rd(16'h0022, "R5");
    rd(16'h0033, "R5");

    // R8 / R7 flags and status clear
    done_pulse(4'd5);
    @(negedge clk);
    chk("R8 int set", int_flags, 16'h0020);
    cmd(8'h55); rd(16'h0009, "R7 int+full"); @(negedge clk);
    chk("R7 int cleared", int_flags, 16'h0000);
    rd(16'h0001, "R7 full kept");
    cmd(8'h15); cmd(8'h55); rd(16'h0000, "R8 full cleared");

    // R9 stall
    cmd(8'h46); cmd(8'h56); rd(16'h0002, "R9 stall set");
    cmd(8'h66); cmd(8'h56); rd(16'h0000, "R9 stall clr");
    cmd(8'h40); cmd(8'h41); setup_pulse(); @(negedge clk);
    chk("R9 setup int", int_flags, 16'h0001);
    cmd(8'h50); rd(16'h0008, "R9 setup ep0");
    cmd(8'h51); rd(16'h0000, "R9 setup ep1");

    // R10 double-buffered endpoint 2 under DMA
    wide_bus = 1'b1; dma_act = 1'b1;
    cmd(8'h02); wr(16'h0000); wr(16'h0040);
    for (int j = 0; j < 32; j++) wr({8'(2*j+1), 8'(2*j)});
    dma_act = 1'b0;
    cmd(8'h52); rd(16'h0004, "R10 bank flipped");
    cmd(8'h12); rd(16'h0000, "R10"); rd(16'h0000, "R10 other bank len");
    cmd(8'h02); wr(16'h0000); wr(16'h0002); wr(16'hBEEF);
    cmd(8'h12); rd(16'h0000, "R10"); rd(16'h0002, "R10"); rd(16'hBEEF, "R10");

    // R10 single-buffered endpoint 3 wraps
    dma_act = 1'b1;
    cmd(8'h03); wr(16'h0000); wr(16'h0040);
    for (int j = 0; j < 32; j++) wr(16'h1000 + 16'(j));
    wr(16'h7777);
    dma_act = 1'b0;
    cmd(8'h53); rd(16'h0000, "R10 no flip");
    cmd(8'h13); rd(16'h0000, "R10"); rd(16'h0040, "R10 len"); rd(16'h7777, "R10 wrap");
    rd(16'h1001, "R10 wrap next");

    // R11 hold
    repeat (4) @(negedge clk);
    chk("R11 hold", dout, last_exp);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("scoreboard drain", 16'(exp_q.size()), 16'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule